// File: doc/BRIEF.md
# Hart Debug-Mode Entry Controller

This block decides when a hart stops running its program and enters debug mode, and it holds the registers a debugger uses while the hart is halted. Four requests can cause an entry: a hit from the breakpoint logic, an `ebreak` that the current privilege level allows to enter debug mode, a halt request from the debugger, and the end of a single step. When several of these arrive in the same cycle, a fixed priority picks one. The block then records a cause code, a resume address and the privilege level in effect, and raises the debug-mode flag on the next clock edge.

While the hart is halted, the debugger reads and writes a debug control/status register, a debug PC register and two scratch registers through a single-cycle CSR port. A debug-return request ends debug mode. In the same cycle the block presents the saved resume address and privilege to the core, and the flag drops on the next edge. Two gating outputs tell the counter and timer logic to stop while the hart is halted.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset, debugMode is 0. The control/status register (address 0x7b0) reads 0x40000003: version field 31:28 = 4, privilege field 1:0 = 3 (machine), all other bits 0. The debug PC (0x7b1) and both scratch registers (0x7b2, 0x7b3) read 0.
- R2: csrHit is 1 and csrRdata returns the register for addresses 0x7b0 to 0x7b3. For any other address, csrHit is 0 and csrRdata is 0. The debug PC and both scratch registers read back the full word last written.
- R3: In the control/status register, the writable bits are 15, 13, 12, 10, 9, 2 and 1:0. Bits 31:28 always read 4. Bits 11 and 4 read 0. The cause field 8:6 ignores writes. Bit 3 shows nmiPending.
- R4: The cause field reads 1 for an ebreak entry, 2 for a breakpoint hit, 3 for a halt request and 4 for a step. When requests coincide, the breakpoint hit wins, then ebreak, then halt request, then step.
- R5: ebreakValid causes an entry only when the enable bit for curPriv is set: bit 15 for machine (3), bit 13 for supervisor (1), bit 12 for user (0). Otherwise it is ignored.
- R6: With bit 2 set and the hart outside debug mode, stepDone causes an entry with cause 4. With bit 2 clear, stepDone is ignored.
- R7: On a breakpoint or ebreak entry, the debug PC captures instrPc. On a halt or step entry, it captures nextPc.
- R8: debugMode rises on the clock edge that accepts an entry. In that same update, bits 1:0 capture curPriv.
- R9: While debugMode is 1, entry requests are ignored: debugMode, cause, privilege and debug PC keep their values.
- R10: With dretReq high in debug mode, resumeValid is 1 in that cycle, resumePc equals the debug PC and resumePriv equals bits 1:0. debugMode clears on the next edge. dretReq outside debug mode is ignored.
- R11: A write of 2 to bits 1:0 reads back as 3. The values 0, 1 and 3 read back unchanged.
- R12: counterStop = bit10 AND (debugMode OR an ebreak entry being accepted this cycle). timerStop = bit9 AND debugMode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| haltReq | input | 1 | Debugger asks the hart to halt |
| ebreakValid | input | 1 | An ebreak instruction is executing |
| triggerHit | input | 1 | Breakpoint logic matched the current instruction |
| stepDone | input | 1 | One instruction completed or trapped |
| curPriv | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| instrPc | input | XLEN | Address of the current instruction |
| nextPc | input | XLEN | Address of the instruction that would run next |
| nmiPending | input | 1 | Non-maskable interrupt pending flag |
| dretReq | input | 1 | Debug-return request |
| csrAddr | input | 12 | CSR address |
| csrWe | input | 1 | CSR write strobe |
| csrWdata | input | XLEN | CSR write data |
| csrRdata | output | XLEN | CSR read data, combinational |
| csrHit | output | 1 | Address selects a register of this block |
| debugMode | output | 1 | Hart is in debug mode |
| resumeValid | output | 1 | Debug return accepted this cycle |
| resumePc | output | XLEN | Address to resume at |
| resumePriv | output | 2 | Privilege to resume in |
| counterStop | output | 1 | Freeze cycle and instret counters |
| timerStop | output | 1 | Freeze hart-local timers |

## Verification
A wrong internal state in this block shows up within one cycle of an entry or a return. A wrong priority decision or PC source shows as a wrong cause code or debug PC on the first CSR read after debugMode rises. A stale flag appears at the ports as a missing resumeValid, or as an entry that should have been blocked and instead overwrites the cause or debug PC. A counter freeze in the wrong cycle can be seen at counterStop during the very cycle the ebreak is presented. Errors in the legalisation of the privilege field can be seen on the next read and again at resumePriv on the following return.

// File: rtl/dbgctl_pkg.sv
`timescale 1ns/1ps
package dbgctl_pkg;
  localparam int CSR_ADDR_W = 12;
  localparam int CTRL_W     = 32;

  localparam logic [CSR_ADDR_W-1:0] ADDR_DCTRL    = 12'h7b0;
  localparam logic [CSR_ADDR_W-1:0] ADDR_DRESUME  = 12'h7b1;
  localparam logic [CSR_ADDR_W-1:0] ADDR_SCRATCH0 = 12'h7b2;

  localparam logic [3:0] DEBUG_VERSION = 4'd4;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_EBREAK  = 3'd1,
    CAUSE_TRIGGER = 3'd2,
    CAUSE_HALT    = 3'd3,
    CAUSE_STEP    = 3'd4
  } entryCause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        enter;
    entryCause_e cause;
    logic        useInstrPc;
    logic        leave;
  } dbgStrobe_t;

  // configuration bits held in the datapath, consumed by control
  typedef struct packed {
    logic ebM;
    logic ebS;
    logic ebU;
    logic step;
    logic stopCount;
    logic stopTime;
  } dbgCfg_t;

  function automatic logic [1:0] legalPriv(input logic [1:0] p);
    return (p == 2'd2) ? PRIV_M : p;
  endfunction
endpackage

// File: rtl/dbg_ctrl.sv
`timescale 1ns/1ps
module dbg_ctrl
  import dbgctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltReq,
  input  logic       ebreakValid,
  input  logic       triggerHit,
  input  logic       stepDone,
  input  logic [1:0] curPriv,
  input  logic       dretReq,
  input  dbgCfg_t    cfg,
  output dbgStrobe_t strobe,
  output logic       debugMode,
  output logic       counterStop,
  output logic       timerStop,
  output logic       resumeValid
);
  logic ebreakArmed;
  logic ebreakOk;
  logic stepOk;

  always_comb begin
    case (curPriv)
      PRIV_M:  ebreakArmed = cfg.ebM;
      PRIV_S:  ebreakArmed = cfg.ebS;
      PRIV_U:  ebreakArmed = cfg.ebU;
      default: ebreakArmed = 1'b0;
    endcase
    ebreakOk = ebreakValid && ebreakArmed;
    stepOk   = stepDone && cfg.step;
  end

  // fixed priority: trigger > ebreak > halt > step
  always_comb begin
    strobe            = '0;
    strobe.cause      = CAUSE_NONE;
    if (!debugMode) begin
      if (triggerHit) begin
        strobe.enter      = 1'b1;
        strobe.cause      = CAUSE_TRIGGER;
        strobe.useInstrPc = 1'b1;
      end else if (ebreakOk) begin
        strobe.enter      = 1'b1;
        strobe.cause      = CAUSE_EBREAK;
        strobe.useInstrPc = 1'b1;
      end else if (haltReq) begin
        strobe.enter      = 1'b1;
        strobe.cause      = CAUSE_HALT;
      end else if (stepOk) begin
        strobe.enter      = 1'b1;
        strobe.cause      = CAUSE_STEP;
      end
    end else begin
      strobe.leave = dretReq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             debugMode <= 1'b0;
    else if (strobe.enter) debugMode <= 1'b1;
    else if (strobe.leave) debugMode <= 1'b0;
  end

  always_comb begin
    counterStop = cfg.stopCount &&
                  (debugMode || (strobe.enter && strobe.cause == CAUSE_EBREAK));
    timerStop   = cfg.stopTime && debugMode;
    resumeValid = strobe.leave;
  end

  assert_enter_sets_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enter |=> debugMode);
  assert_return_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (debugMode && dretReq) |=> !debugMode);
  assert_halted_stays_R9: assert property (@(posedge clk) disable iff (!rstN)
    (debugMode && !dretReq) |=> debugMode);
  assert_no_entry_halted_R9: assert property (@(posedge clk) disable iff (!rstN)
    debugMode |-> !strobe.enter);
endmodule

// File: rtl/dbg_datapath.sv
`timescale 1ns/1ps
module dbg_datapath
  import dbgctl_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NUM_SCRATCH = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dbgStrobe_t            strobe,
  input  logic [1:0]            curPriv,
  input  logic [XLEN-1:0]       instrPc,
  input  logic [XLEN-1:0]       nextPc,
  input  logic                  nmiPending,
  input  logic [CSR_ADDR_W-1:0] csrAddr,
  input  logic                  csrWe,
  input  logic [XLEN-1:0]       csrWdata,
  output logic [XLEN-1:0]       csrRdata,
  output logic                  csrHit,
  output dbgCfg_t               cfg,
  output logic [XLEN-1:0]       dpcOut,
  output logic [1:0]            privOut
);
  localparam int PAD_W = XLEN - CTRL_W;

  entryCause_e     causeQ;
  logic [1:0]      prvQ;
  logic [XLEN-1:0] dpcQ;
  logic [XLEN-1:0] scratchQ [NUM_SCRATCH];
  logic            wrCtrl;
  logic            wrDpc;
  logic [CTRL_W-1:0] ctrlView;

  assign wrCtrl = csrWe && (csrAddr == ADDR_DCTRL);
  assign wrDpc  = csrWe && (csrAddr == ADDR_DRESUME);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg    <= '0;
      causeQ <= CAUSE_NONE;
      prvQ   <= PRIV_M;
      dpcQ   <= '0;
    end else begin
      if (wrCtrl) begin
        cfg.ebM       <= csrWdata[15];
        cfg.ebS       <= csrWdata[13];
        cfg.ebU       <= csrWdata[12];
        cfg.stopCount <= csrWdata[10];
        cfg.stopTime  <= csrWdata[9];
        cfg.step      <= csrWdata[2];
        prvQ          <= legalPriv(csrWdata[1:0]);
      end
      if (strobe.enter) begin
        causeQ <= strobe.cause;
        prvQ   <= legalPriv(curPriv);
        dpcQ   <= strobe.useInstrPc ? instrPc : nextPc;
      end else if (wrDpc) begin
        dpcQ   <= csrWdata;
      end
    end
  end

  for (genvar g = 0; g < NUM_SCRATCH; g++) begin : gScratch
    localparam logic [CSR_ADDR_W-1:0] MY_ADDR = ADDR_SCRATCH0 + CSR_ADDR_W'(g);
    always_ff @(posedge clk) begin
      if (!rstN)                               scratchQ[g] <= '0;
      else if (csrWe && csrAddr == MY_ADDR)    scratchQ[g] <= csrWdata;
    end
  end

  assign ctrlView = {DEBUG_VERSION, 12'd0, cfg.ebM, 1'b0, cfg.ebS, cfg.ebU,
                     1'b0, cfg.stopCount, cfg.stopTime, causeQ, 2'b00,
                     nmiPending, cfg.step, prvQ};

  always_comb begin
    csrRdata = '0;
    csrHit   = 1'b0;
    if (csrAddr == ADDR_DCTRL) begin
      csrRdata = {{PAD_W{1'b0}}, ctrlView};
      csrHit   = 1'b1;
    end else if (csrAddr == ADDR_DRESUME) begin
      csrRdata = dpcQ;
      csrHit   = 1'b1;
    end
    for (int i = 0; i < NUM_SCRATCH; i++) begin
      if (csrAddr == ADDR_SCRATCH0 + CSR_ADDR_W'(i)) begin
        csrRdata = scratchQ[i];
        csrHit   = 1'b1;
      end
    end
  end

  assign dpcOut  = dpcQ;
  assign privOut = prvQ;

  assert_priv_legal_R11: assert property (@(posedge clk) disable iff (!rstN)
    prvQ != 2'd2);
  assert_cause_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enter |=> (causeQ != CAUSE_NONE && causeQ <= CAUSE_STEP));
  assert_dpc_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enter && strobe.useInstrPc) |=> dpcQ == $past(instrPc));
  assert_dpc_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.enter && !wrDpc) |=> $stable(dpcQ));
endmodule

// File: rtl/dbg_entry_ctrl.sv
`timescale 1ns/1ps
module dbg_entry_ctrl
  import dbgctl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            haltReq,
  input  logic            ebreakValid,
  input  logic            triggerHit,
  input  logic            stepDone,
  input  logic [1:0]      curPriv,
  input  logic [XLEN-1:0] instrPc,
  input  logic [XLEN-1:0] nextPc,
  input  logic            nmiPending,
  input  logic            dretReq,
  input  logic [11:0]     csrAddr,
  input  logic            csrWe,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] csrRdata,
  output logic            csrHit,
  output logic            debugMode,
  output logic            resumeValid,
  output logic [XLEN-1:0] resumePc,
  output logic [1:0]      resumePriv,
  output logic            counterStop,
  output logic            timerStop
);
  dbgStrobe_t strobe;
  dbgCfg_t    cfg;

  dbg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .ebreakValid(ebreakValid),
    .triggerHit(triggerHit), .stepDone(stepDone), .curPriv(curPriv),
    .dretReq(dretReq), .cfg(cfg), .strobe(strobe), .debugMode(debugMode),
    .counterStop(counterStop), .timerStop(timerStop), .resumeValid(resumeValid)
  );

  dbg_datapath #(.XLEN(XLEN), .NUM_SCRATCH(2)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curPriv(curPriv),
    .instrPc(instrPc), .nextPc(nextPc), .nmiPending(nmiPending),
    .csrAddr(csrAddr), .csrWe(csrWe), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .csrHit(csrHit), .cfg(cfg),
    .dpcOut(resumePc), .privOut(resumePriv)
  );
endmodule

// File: tb/tb_dbg_entry_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_entry_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic        haltReq, ebreakValid, triggerHit, stepDone;
  logic [1:0]  curPriv;
  logic [31:0] instrPc, nextPc;
  logic        nmiPending, dretReq;
  logic [11:0] csrAddr;
  logic        csrWe;
  logic [31:0] csrWdata;
  logic [31:0] csrRdata;
  logic        csrHit, debugMode, resumeValid;
  logic [31:0] resumePc;
  logic [1:0]  resumePriv;
  logic        counterStop, timerStop;

  dbg_entry_ctrl #(.XLEN(32)) dut (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .ebreakValid(ebreakValid),
    .triggerHit(triggerHit), .stepDone(stepDone), .curPriv(curPriv),
    .instrPc(instrPc), .nextPc(nextPc), .nmiPending(nmiPending),
    .dretReq(dretReq), .csrAddr(csrAddr), .csrWe(csrWe), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .csrHit(csrHit), .debugMode(debugMode),
    .resumeValid(resumeValid), .resumePc(resumePc), .resumePriv(resumePriv),
    .counterStop(counterStop), .timerStop(timerStop)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;

  // bench model
  logic       mEbM, mEbS, mEbU, mStep, mSc, mSt, mDebug;
  logic [2:0] mCause;
  logic [1:0] mPrv;
  logic [31:0] mDpc;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fixPriv(input logic [1:0] p);
    return (p == 2'd2) ? 2'd3 : p;
  endfunction

  function automatic logic [31:0] expCtrl();
    return {4'd4, 12'd0, mEbM, 1'b0, mEbS, mEbU, 1'b0, mSc, mSt, mCause,
            2'b00, nmiPending, mStep, mPrv};
  endfunction

  task automatic csrWr(input logic [11:0] a, input logic [31:0] d);
    csrAddr = a; csrWdata = d; csrWe = 1'b1;
    @(posedge clk); @(negedge clk);
    csrWe = 1'b0;
    if (a == 12'h7b0) begin
      mEbM = d[15]; mEbS = d[13]; mEbU = d[12]; mSc = d[10]; mSt = d[9];
      mStep = d[2]; mPrv = fixPriv(d[1:0]);
    end else if (a == 12'h7b1) begin
      mDpc = d;
    end
  endtask

  task automatic csrRd(input logic [11:0] a, output logic [31:0] d);
    csrAddr = a; #1; d = csrRdata;
  endtask

  task automatic fire(input logic trg, input logic ebk, input logic hlt,
                      input logic stp, input logic [1:0] prv,
                      input logic [31:0] ipc, input logic [31:0] npc);
    logic armed, entering;
    logic [2:0] code;
    logic [31:0] rd;
    logic wasDebug;
    armed = (prv == 2'd3) ? mEbM : (prv == 2'd1) ? mEbS : (prv == 2'd0) ? mEbU : 1'b0;
    entering = 1'b0; code = 3'd0;
    wasDebug = mDebug;
    if (!mDebug) begin
      if (trg)                 begin entering = 1'b1; code = 3'd2; end
      else if (ebk && armed)   begin entering = 1'b1; code = 3'd1; end
      else if (hlt)            begin entering = 1'b1; code = 3'd3; end
      else if (stp && mStep)   begin entering = 1'b1; code = 3'd4; end
    end
    triggerHit = trg; ebreakValid = ebk; haltReq = hlt; stepDone = stp;
    curPriv = prv; instrPc = ipc; nextPc = npc;
    #1;
    chk("R12 counterStop", counterStop, mSc && (mDebug || (entering && code == 3'd1)));
    @(posedge clk); @(negedge clk);
    triggerHit = 0; ebreakValid = 0; haltReq = 0; stepDone = 0;
    if (entering) begin
      mDebug = 1'b1; mCause = code; mPrv = fixPriv(prv);
      mDpc = (code == 3'd1 || code == 3'd2) ? ipc : npc;
    end
    chk(wasDebug ? "R9 debugMode" : "R8 debugMode", debugMode, mDebug);
    csrRd(12'h7b0, rd);
    chk(wasDebug ? "R9 ctrl" : "R4 cause/priv ctrl", rd, expCtrl());
    csrRd(12'h7b1, rd);
    chk(wasDebug ? "R9 dpc" : "R7 dpc", rd, mDpc);
    chk("R12 timerStop", timerStop, mSt && mDebug);
  endtask

  task automatic doRet();
    dretReq = 1'b1; #1;
    chk("R10 resumeValid", resumeValid, mDebug);
    if (mDebug) begin
      chk("R10 resumePc", resumePc, mDpc);
      chk("R10 resumePriv", resumePriv, mPrv);
    end
    @(posedge clk); @(negedge clk);
    dretReq = 1'b0;
    mDebug = 1'b0;
    chk("R10 debugMode after return", debugMode, 1'b0);
  endtask

  initial begin
    #(20 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd2024));
    rstN = 0; haltReq = 0; ebreakValid = 0; triggerHit = 0; stepDone = 0;
    curPriv = 2'd3; instrPc = 0; nextPc = 0; nmiPending = 0; dretReq = 0;
    csrAddr = 12'h7b0; csrWe = 0; csrWdata = 0;
    mEbM = 0; mEbS = 0; mEbU = 0; mStep = 0; mSc = 0; mSt = 0; mDebug = 0;
    mCause = 0; mPrv = 2'd3; mDpc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state
    chk("R1 debugMode", debugMode, 1'b0);
    csrRd(12'h7b0, rd); chk("R1 ctrl", rd, 32'h40000003);
    csrRd(12'h7b1, rd); chk("R1 dpc", rd, 32'h0);
    csrRd(12'h7b2, rd); chk("R1 scratch0", rd, 32'h0);
    csrRd(12'h7b3, rd); chk("R1 scratch1", rd, 32'h0);

    // R2 map and scratch
    csrWr(12'h7b2, 32'hdeadbeef);
    csrWr(12'h7b3, 32'h12345678);
    csrRd(12'h7b2, rd); chk("R2 scratch0", rd, 32'hdeadbeef);
    csrRd(12'h7b3, rd); chk("R2 scratch1", rd, 32'h12345678);
    csrWr(12'h7b1, 32'hcafe0004);
    csrRd(12'h7b1, rd); chk("R2 dpc rw", rd, 32'hcafe0004);
    csrRd(12'h7b4, rd); chk("R2 unmapped data", rd, 32'h0);
    chk("R2 unmapped hit", csrHit, 1'b0);
    csrAddr = 12'h7b0; #1; chk("R2 mapped hit", csrHit, 1'b1);

    // R3 hard-wired bits, cause not writable, nmi flag
    csrWr(12'h7b0, 32'hffffffff);
    nmiPending = 1'b1;
    csrRd(12'h7b0, rd); chk("R3 ctrl all ones", rd, expCtrl());
    chk("R3 ctrl value", rd, 32'h4000b60f);
    nmiPending = 1'b0;
    // R11 privilege legalisation
    csrWr(12'h7b0, 32'h00000002);
    csrRd(12'h7b0, rd); chk("R11 prv 2->3", rd[1:0], 2'd3);
    csrWr(12'h7b0, 32'h00000001);
    csrRd(12'h7b0, rd); chk("R11 prv 1", rd[1:0], 2'd1);

    // R4 priority: all four -> trigger
    csrWr(12'h7b0, 32'h0000b404);
    fire(1, 1, 1, 1, 2'd3, 32'h100, 32'h104);
    chk("R4 all four -> trigger", mCause, 3'd2);
    doRet();
    fire(0, 1, 1, 1, 2'd3, 32'h200, 32'h204);   // ebreak over halt, R12 stopcount
    doRet();
    fire(0, 0, 1, 1, 2'd1, 32'h300, 32'h304);   // halt over step
    // R9 requests while halted ignored
    fire(1, 1, 1, 1, 2'd0, 32'h999, 32'h99c);
    doRet();
    // R10 return outside debug mode ignored
    doRet();
    // R6 step alone
    fire(0, 0, 0, 1, 2'd0, 32'h400, 32'h404);
    doRet();
    // R6 step disabled
    csrWr(12'h7b0, 32'h0000b000);
    fire(0, 0, 0, 1, 2'd3, 32'h500, 32'h504);
    // R5 ebreak in user mode disabled
    csrWr(12'h7b0, 32'h0000a000);
    fire(0, 1, 0, 0, 2'd0, 32'h600, 32'h604);
    fire(0, 1, 0, 0, 2'd1, 32'h700, 32'h704);   // supervisor enabled
    doRet();

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [31:0] cw;
      logic [1:0]  p;
      cw = $urandom & 32'h0000b607;
      csrWr(12'h7b0, cw);
      nmiPending = $urandom % 2;
      p = $urandom % 3; if (p == 2'd2) p = 2'd3;
      fire($urandom % 4 == 0, $urandom % 2, $urandom % 3 == 0, $urandom % 2,
           p, $urandom, $urandom);
      if (mDebug) begin
        if ($urandom % 2) fire($urandom % 2, 1, 1, 1, 2'd0, $urandom, $urandom);
        doRet();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule